// File: doc/BRIEF.md
# Converter Conversion and Power Sequencer

This block is the digital control core of an 8-bit sampling converter that is started and powered down from a single pin. A falling edge on the active-low convert-start input `start_n` opens a conversion. The block drives the track/hold control to hold for a fixed window and keeps the conversion busy for a fixed number of cycles. At the end it captures the digitizer's 8-bit word, raises an end-of-conversion pulse, and reads the level of `start_n` to decide whether to stay powered or to shut down. The analog track/hold, the comparators and the reference lie outside this block. They appear here only as control outputs and as a sample-data input.

A separate active-low power-down input forces shutdown at any time. Power-up lasts one of two parameterised lengths, selected by `int_ref`: a short one for an external reference and a long one for the internal reference. With an external reference, a start edge that arrives during power-up is held pending and fires as soon as power-up completes. With the internal reference, such an edge is dropped and a sticky flag is set. The parallel-port output enable is a plain combination of chip-select and read. All durations are counted in clock cycles and set by parameters.

Top module: `adc_conv_sequencer`

## Requirements
- R1: While ready, a falling edge on `start_n` starts a conversion. `hold_o` and `busy_o` are high in the cycle after the clock edge that sees the edge, and `ready_o` goes low.
- R2: `hold_o` stays high for exactly HOLD_CYC cycles and then returns low (track). `busy_o` stays high for exactly CONV_CYC cycles.
- R3: In the first cycle after `busy_o` falls, `eoc_o` is high and `result_o` holds the `sample_data` value present in the last busy cycle. `eoc_o` stays high for exactly EOC_CYC cycles.
- R4: The level of `start_n` in the last busy cycle decides the next state. High (1) returns the block to ready with `pwr_en_o` high. Low (0) powers it down: `pwr_en_o` and `ready_o` go low.
- R5: `pdn_n` low forces the powered-down state one cycle later from any state, including mid-conversion. `pwr_en_o`, `busy_o` and `hold_o` go low, and the aborted conversion produces no `eoc_o`.
- R6: After reset, `start_n` edges do not power the block up. Only a rising edge on `pdn_n` does.
- R7: After a shutdown caused by the end-of-conversion check, a rising edge on `start_n` (or on `pdn_n`) starts power-up.
- R8: `pwr_en_o` is high from the cycle after the wake edge. `ready_o` rises PWUP_EXT_CYC cycles after that when `int_ref`=0, or PWUP_INT_CYC cycles after it when `int_ref`=1.
- R9: With `int_ref`=0, a `start_n` falling edge during power-up is held. `busy_o` rises exactly when power-up completes, and `ready_o` is not raised in between.
- R10: With `int_ref`=1, a `start_n` falling edge during power-up starts no conversion. `early_start_err_o` goes high in the next cycle and stays high until reset.
- R11: A `start_n` falling edge during a conversion is ignored. The conversion keeps its length and produces one `eoc_o` pulse.
- R12: `bus_oe_o` is high (drive) only while `cs_n` and `rd_n` are both 0. Otherwise it is low (high impedance).
- R13: After reset, `pwr_en_o`, `ready_o`, `busy_o`, `hold_o`, `eoc_o` and `early_start_err_o` are 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Convert-start; falling edge starts, level checked at end |
| pdn_n | input | 1 | Active-low power-down; rising edge wakes |
| int_ref | input | 1 | 1 selects the internal-reference power-up length and rules |
| cs_n | input | 1 | Active-low chip-select of the parallel port |
| rd_n | input | 1 | Active-low read of the parallel port |
| sample_data | input | DATA_W | Word from the digitizer stub |
| hold_o | output | 1 | Track/hold control, 1 = hold |
| busy_o | output | 1 | Conversion in progress |
| ready_o | output | 1 | Powered and idle |
| pwr_en_o | output | 1 | Analog power enable (waking, ready or busy) |
| eoc_o | output | 1 | End-of-conversion pulse |
| result_o | output | DATA_W | Latched conversion result |
| bus_oe_o | output | 1 | Data-bus output enable |
| early_start_err_o | output | 1 | Sticky: start edge during internal-reference power-up |

## Verification
Some rules are checked by the embedded properties on every cycle. Each accepted start edge must lead to hold and busy, and a mid-conversion cycle must always advance the counter. Shutdown must follow a low power-down pin. Every conversion end must raise the pulse with the captured word, and a pending start must land on the last power-up cycle. The error flag must never clear. The window lengths, the two power-up durations, and the choice between shutting down and staying powered are shown only by the bench scenarios. So are the rule that start edges cannot wake a freshly reset block, and the ignored mid-conversion edge as seen from the pins.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF_PIN  = 3'd0,
    ST_OFF_AUTO = 3'd1,
    ST_WAKE     = 3'd2,
    ST_IDLE     = 3'd3,
    ST_CONV     = 3'd4
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/seq_edge_det.sv
module seq_edge_det #(
  parameter int unsigned    N       = 2,
  parameter logic [N-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= RST_VAL[i];
      else        prev_q[i] <= din[i];
    end
    assign rise[i] = din[i] & ~prev_q[i];
    assign fall[i] = ~din[i] & prev_q[i];
  end

endmodule

// File: rtl/seq_pulse_gen.sv
module seq_pulse_gen #(
  parameter int unsigned WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);

  localparam int unsigned PW = (WIDTH < 1) ? 1 : WIDTH;
  localparam int unsigned CW = $clog2(PW + 1);

  logic [CW-1:0] left_q, left_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = trig || (left_q != '0);
    if (trig) left_d = CW'(PW);
    else      left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left_q <= '0;
    else if (cnt_en) left_q <= left_d;
  end

  assign pulse = (left_q != '0);

  assert_pulse_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pulse);

endmodule

// File: rtl/seq_bus_gate.sv
module seq_bus_gate (
  input  logic sel_n,
  input  logic rd_n,
  output logic oe
);

  always_comb oe = ~(sel_n | rd_n);

endmodule

// File: rtl/seq_power_fsm.sv
module seq_power_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYC     = 24,
  parameter int unsigned CONV_CYC     = 84,
  parameter int unsigned PWUP_EXT_CYC = 200,
  parameter int unsigned PWUP_INT_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_lvl,
  input  logic start_fall,
  input  logic start_rise,
  input  logic pdn_lvl,
  input  logic pdn_rise,
  input  logic pdn_fall,
  input  logic int_ref,
  output logic hold_o,
  output logic busy_o,
  output logic ready_o,
  output logic pwr_en_o,
  output logic conv_done_o,
  output logic err_o
);

  localparam int unsigned CNT_MAX   = max3(CONV_CYC, PWUP_EXT_CYC, PWUP_INT_CYC);
  localparam int unsigned CW        = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYC - 1);
  localparam logic [CW-1:0] EXT_LAST  = CW'(PWUP_EXT_CYC - 1);
  localparam logic [CW-1:0] INT_LAST  = CW'(PWUP_INT_CYC - 1);
  localparam logic [CW-1:0] HOLD_LEN  = CW'(HOLD_CYC);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          err_q, err_d;
  logic [CW-1:0] wake_last;
  logic          done_c;

  assign wake_last = int_ref ? INT_LAST : EXT_LAST;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    err_d   = err_q;
    done_c  = 1'b0;
    unique case (state_q)
      ST_OFF_PIN: begin
        if (pdn_rise) begin
          state_d = ST_WAKE;
          cnt_d   = '0;
        end
      end
      ST_OFF_AUTO: begin
        if (pdn_rise || start_rise) begin
          state_d = ST_WAKE;
          cnt_d   = '0;
        end
      end
      ST_WAKE: begin
        if (start_fall) begin
          if (int_ref) err_d  = 1'b1;
          else         pend_d = 1'b1;
        end
        if (cnt_q == wake_last) begin
          state_d = (pend_q || (start_fall && !int_ref)) ? ST_CONV : ST_IDLE;
          cnt_d   = '0;
          pend_d  = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_IDLE: begin
        if (start_fall) begin
          state_d = ST_CONV;
          cnt_d   = '0;
        end
      end
      ST_CONV: begin
        if (cnt_q == CONV_LAST) begin
          done_c  = 1'b1;
          state_d = start_lvl ? ST_IDLE : ST_OFF_AUTO;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_OFF_PIN;
        cnt_d   = '0;
      end
    endcase
    if (!pdn_lvl) begin
      state_d = ST_OFF_PIN;
      cnt_d   = '0;
      pend_d  = 1'b0;
      done_c  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF_PIN;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      err_q   <= err_d;
    end
  end

  assign busy_o      = (state_q == ST_CONV);
  assign hold_o      = busy_o && (cnt_q < HOLD_LEN);
  assign ready_o     = (state_q == ST_IDLE);
  assign pwr_en_o    = (state_q == ST_WAKE) || ready_o || busy_o;
  assign conv_done_o = done_c;
  assign err_o       = err_q;

  assert_hold_follows_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && start_fall && pdn_lvl) |=> (hold_o && busy_o));

  assert_mid_conv_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (cnt_q != CONV_LAST) && pdn_lvl) |=> (busy_o && (cnt_q == CW'($past(cnt_q) + 1'b1))));

  assert_pin_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pdn_lvl || pdn_fall) |=> !pwr_en_o);

  assert_pend_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAKE) && pend_q && (cnt_q == wake_last) && pdn_lvl) |=> busy_o);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned HOLD_CYC     = 24,
  parameter int unsigned CONV_CYC     = 84,
  parameter int unsigned EOC_CYC      = 4,
  parameter int unsigned PWUP_EXT_CYC = 200,
  parameter int unsigned PWUP_INT_CYC = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic              pdn_n,
  input  logic              int_ref,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] sample_data,
  output logic              hold_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic              pwr_en_o,
  output logic              eoc_o,
  output logic [DATA_W-1:0] result_o,
  output logic              bus_oe_o,
  output logic              early_start_err_o
);

  localparam int unsigned N_EDGE = 2;
  localparam int unsigned IX_ST  = 0;
  localparam int unsigned IX_PD  = 1;

  logic              rst_meta_q, rst_sync_q;
  logic [N_EDGE-1:0] pin_lvl, pin_rise, pin_fall;
  logic              conv_done;
  logic [DATA_W-1:0] result_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign pin_lvl[IX_ST] = start_n;
  assign pin_lvl[IX_PD] = pdn_n;

  seq_edge_det #(
    .N       (N_EDGE),
    .RST_VAL ('1)
  ) edge_i (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .din  (pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  seq_power_fsm #(
    .HOLD_CYC    (HOLD_CYC),
    .CONV_CYC    (CONV_CYC),
    .PWUP_EXT_CYC(PWUP_EXT_CYC),
    .PWUP_INT_CYC(PWUP_INT_CYC)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .start_lvl  (start_n),
    .start_fall (pin_fall[IX_ST]),
    .start_rise (pin_rise[IX_ST]),
    .pdn_lvl    (pdn_n),
    .pdn_rise   (pin_rise[IX_PD]),
    .pdn_fall   (pin_fall[IX_PD]),
    .int_ref    (int_ref),
    .hold_o     (hold_o),
    .busy_o     (busy_o),
    .ready_o    (ready_o),
    .pwr_en_o   (pwr_en_o),
    .conv_done_o(conv_done),
    .err_o      (early_start_err_o)
  );

  seq_pulse_gen #(
    .WIDTH(EOC_CYC)
  ) eoc_i (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .trig (conv_done),
    .pulse(eoc_o)
  );

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)    result_q <= '0;
    else if (conv_done) result_q <= sample_data;
  end

  assign result_o = result_q;

  seq_bus_gate bus_i (
    .sel_n(cs_n),
    .rd_n (rd_n),
    .oe   (bus_oe_o)
  );

  assert_result_on_eoc_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    conv_done |=> (eoc_o && (result_o == $past(sample_data))));

endmodule

// File: tb/adc_conv_sequencer_tb_top.sv
`timescale 1ns/100ps
module adc_conv_sequencer_tb_top;

  localparam int HOLD = 3;
  localparam int CONV = 8;
  localparam int EOCW = 2;
  localparam int PWE  = 10;
  localparam int PWI  = 30;

  logic       clk = 1'b0;
  logic       rst_n, start_n, pdn_n, int_ref, cs_n, rd_n;
  logic [7:0] sdata;
  logic       hold, busy, ready, pwr_en, eoc, bus_oe, err;
  logic [7:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  adc_conv_sequencer #(
    .DATA_W(8), .HOLD_CYC(HOLD), .CONV_CYC(CONV), .EOC_CYC(EOCW),
    .PWUP_EXT_CYC(PWE), .PWUP_INT_CYC(PWI)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .pdn_n(pdn_n), .int_ref(int_ref),
    .cs_n(cs_n), .rd_n(rd_n), .sample_data(sdata), .hold_o(hold), .busy_o(busy),
    .ready_o(ready), .pwr_en_o(pwr_en), .eoc_o(eoc), .result_o(result),
    .bus_oe_o(bus_oe), .early_start_err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 0; start_n = 1; pdn_n = 1; int_ref = 0; cs_n = 1; rd_n = 1; sdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R13 pwr_en", pwr_en, 0); chk("R13 ready", ready, 0);
    chk("R13 busy", busy, 0);     chk("R13 hold", hold, 0);
    chk("R13 eoc", eoc, 0);       chk("R13 err", err, 0);
    chk("R13 result", result, 0);
    // R6: start edges do not wake a freshly reset block
    start_n = 0; repeat (2) @(negedge clk);
    start_n = 1; repeat (PWE + 3) @(negedge clk);
    chk("R6 start rise no wake", pwr_en, 0);
    chk("R6 still not ready", ready, 0);
  endtask

  task automatic t_wake(input int pw, input string tag);
    int first_rdy = -1;
    int en0 = 0;
    pdn_n = 0; repeat (2) @(negedge clk);
    pdn_n = 1;
    for (int j = 0; j < pw + 3; j++) begin
      @(negedge clk);
      if (j == 0) en0 = pwr_en;
      if (ready && first_rdy < 0) first_rdy = j;
    end
    chk({tag, " R8 pwr_en at wake"}, en0, 1);
    chk({tag, " R8 wake length"}, first_rdy, pw);
  endtask

  // mode 0: start high at end; 1: start low at end; 2: extra fall mid conversion
  task automatic t_conv(input logic [7:0] d, input int mode, input string tag);
    int n_hold = 0, n_busy = 0, n_eoc = 0, eoc_first = -1, res_at = -1;
    int rdy_end = -1, en_end = -1;
    sdata = d;
    start_n = 0;
    for (int j = 0; j < CONV + EOCW + 2; j++) begin
      @(negedge clk);
      if (j == 0) begin
        chk({tag, " R1 hold after start"}, hold, 1);
        chk({tag, " R1 busy after start"}, busy, 1);
        chk({tag, " R1 ready low"}, ready, 0);
      end
      if (hold) n_hold++;
      if (busy) n_busy++;
      if (eoc) begin n_eoc++; if (eoc_first < 0) eoc_first = j; end
      if (j == CONV) begin res_at = result; rdy_end = ready; en_end = pwr_en; end
      if (j == 1 && mode != 1) start_n = 1;
      if (j == 3 && mode == 2) start_n = 0;
      if (j == 5 && mode == 2) start_n = 1;
    end
    chk({tag, " R2 hold cycles"}, n_hold, HOLD);
    chk({tag, " R2 busy cycles"}, n_busy, CONV);
    chk({tag, " R3 eoc start"}, eoc_first, CONV);
    chk({tag, " R3 eoc width"}, n_eoc, EOCW);
    chk({tag, " R3 result"}, res_at, int'(d));
    chk({tag, " R4 powered after"}, en_end, (mode == 1) ? 0 : 1);
    chk({tag, " R4 ready after"}, rdy_end, (mode == 1) ? 0 : 1);
  endtask

  task automatic t_auto_wake();
    repeat (3) @(negedge clk);
    chk("R4 stays down", pwr_en, 0);
    start_n = 1;
    begin
      int first_rdy = -1;
      for (int j = 0; j < PWE + 3; j++) begin
        @(negedge clk);
        if (ready && first_rdy < 0) first_rdy = j;
      end
      chk("R7 start rise wakes", first_rdy, PWE);
    end
  endtask

  task automatic t_pin_abort();
    int saw_eoc = 0;
    start_n = 0;
    @(negedge clk); start_n = 1;
    @(negedge clk); @(negedge clk);
    pdn_n = 0;
    @(negedge clk);
    chk("R5 pwr_en off", pwr_en, 0);
    chk("R5 busy off", busy, 0);
    chk("R5 hold off", hold, 0);
    for (int j = 0; j < CONV + 2; j++) begin
      @(negedge clk);
      if (eoc) saw_eoc = 1;
    end
    chk("R5 no eoc after abort", saw_eoc, 0);
  endtask

  task automatic t_ext_pend();
    int first_busy = -1, saw_rdy = 0;
    int_ref = 0;
    sdata = 8'h3C;
    pdn_n = 0; repeat (2) @(negedge clk);
    pdn_n = 1;
    for (int j = 0; j < PWE + 3; j++) begin
      @(negedge clk);
      if (busy && first_busy < 0) first_busy = j;
      if (ready) saw_rdy = 1;
      if (j == 2) start_n = 0;
      if (j == 4) start_n = 1;
    end
    chk("R9 pending conv start", first_busy, PWE);
    chk("R9 no ready between", saw_rdy, 0);
    repeat (CONV + EOCW) @(negedge clk);
    chk("R9 pending conv result", result, 8'h3C);
    chk("R9 ready after", ready, 1);
  endtask

  task automatic t_int_ign();
    int first_err = -1, first_rdy = -1, saw_busy = 0;
    int_ref = 1;
    pdn_n = 0; repeat (2) @(negedge clk);
    pdn_n = 1;
    for (int j = 0; j < PWI + 3; j++) begin
      @(negedge clk);
      if (err && first_err < 0) first_err = j;
      if (ready && first_rdy < 0) first_rdy = j;
      if (busy) saw_busy = 1;
      if (j == 2) start_n = 0;
      if (j == 4) start_n = 1;
    end
    chk("R10 err flag timing", first_err, 3);
    chk("R10 no conversion", saw_busy, 0);
    chk("R8 int wake length", first_rdy, PWI);
    t_conv(8'h81, 0, "int");
    chk("R10 err sticky", err, 1);
  endtask

  task automatic t_bus();
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < 2; r++) begin
        cs_n = c[0]; rd_n = r[0];
        #1;
        chk("R12 bus enable", bus_oe, (c == 0 && r == 0) ? 1 : 0);
      end
    end
    cs_n = 1; rd_n = 1;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_wake(PWE, "ext");
    t_conv(8'hA5, 0, "basic");
    t_conv(8'h5A, 2, "R11 midfall");
    t_conv(8'hF0, 1, "autooff");
    t_auto_wake();
    t_conv(8'h0F, 0, "rewoken");
    t_pin_abort();
    t_ext_pend();
    t_int_ign();
    t_bus();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule